// File: doc/BRIEF.md
# Branch Sequencer with Return-Address Stack

This block owns the program counter of a small 16-bit processor whose program space is 4K words. During fetch the control unit pulses an advance strobe and the counter steps by one. When an instruction of the branch class reaches execution, the decoder pulses a separate strobe. With that strobe it supplies the three-bit branch mode and the signed offset field. The block then decides from the negative and zero status flags whether the branch is taken, and it loads the new address.

Subroutine linkage uses a dedicated on-chip LIFO of return addresses, not data memory. A call saves the counter, which already points past the call instruction, and then jumps relative to it. A return restores the most recently saved address. Two sticky error flags record a call that found the stack full and a return that found it empty.

Top module: `seq_pc_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the counter to 0x000, empties the return stack and clears both error flags. A return issued straight after reset therefore reports underflow.
- R2: When only the advance strobe is high, the counter increases by one modulo 4096, so 0xFFF is followed by 0x000.
- R3: Mode 3'b000 always loads counter + sign-extended offset, modulo 4096.
- R4: The conditional modes add the offset only when their test passes: 3'b001 needs Z=0, 3'b010 needs Z=1, 3'b011 needs N=0 and 3'b100 needs N=1. When the test fails, the counter keeps its value.
- R5: Mode 3'b101 changes neither the counter nor the stack.
- R6: Mode 3'b110 (call) saves the current counter on the stack and loads counter + sign-extended offset.
- R7: Mode 3'b111 (return) loads the most recently saved address and removes it. Nested calls come back in reverse order.
- R8: A call made while 16 addresses are held sets the overflow flag, which stays set until reset. The stack contents do not change, but the jump is still taken.
- R9: A return made while the stack is empty sets the underflow flag, which stays set until reset, and leaves the counter unchanged.
- R10: When the branch strobe and the advance strobe are high in the same cycle, the branch alone decides the next counter value.
- R11: The 7-bit offset is two's complement (bit 6 is the sign), so a negative offset moves the counter backwards and wraps below 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Fetch advance strobe |
| br_i | input | 1 | Execute-branch strobe |
| mode_i | input | 3 | Branch mode field |
| offset_i | input | 7 | Signed branch offset field |
| flag_n_i | input | 1 | Negative status flag |
| flag_z_i | input | 1 | Zero status flag |
| pc_o | output | 12 | Program counter |
| ovf_o | output | 1 | Sticky return-stack overflow |
| unf_o | output | 1 | Sticky return-stack underflow |

## Verification
The bench builds the block with its defaults: a 12-bit counter, a 7-bit offset and 16 stack entries. With a 16-deep stack, seventeen nested calls reach the overflow case in a few dozen cycles, and the full unwind that follows checks every stack slot. With a 12-bit counter, a single backwards branch from 0x000 reaches the top-of-space wrap, and the advance that follows wraps the counter back to zero.

// File: rtl/seq_pc_pkg.sv
package seq_pc_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        BM_ALWAYS = 3'b000,
        BM_IF_NZ  = 3'b001,
        BM_IF_Z   = 3'b010,
        BM_IF_NN  = 3'b011,
        BM_IF_N   = 3'b100,
        BM_NONE   = 3'b101,
        BM_CALL   = 3'b110,
        BM_RET    = 3'b111
    } br_mode_e;

    typedef struct packed {
        logic jump;   // load the relative target
        logic call;   // save the current counter first
        logic ret;    // restore from the stack
    } br_act_t;

    // Flag test for the relative branch modes; call counts as always taken.
    function automatic logic mode_taken(br_mode_e m, logic n, logic z);
        case (m)
            BM_ALWAYS: return 1'b1;
            BM_IF_NZ:  return !z;
            BM_IF_Z:   return z;
            BM_IF_NN:  return !n;
            BM_IF_N:   return n;
            BM_CALL:   return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seq_br_decide.sv
module seq_br_decide
    import seq_pc_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFF_W = 7
) (
    input  br_mode_e            mode,
    input  logic                flag_n,
    input  logic                flag_z,
    input  logic [PC_W-1:0]     pc,
    input  logic [OFF_W-1:0]    offset,
    output br_act_t             act,
    output logic [PC_W-1:0]     target
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] off_ext;

    assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign target  = pc + off_ext;

    always_comb begin
        act      = '0;
        act.jump = mode_taken(mode, flag_n, flag_z);
        act.call = (mode == BM_CALL);
        act.ret  = (mode == BM_RET);
    end

endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int PC_W  = 12,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] din,
    output logic [PC_W-1:0] top,
    output logic            full,
    output logic            empty
);
    // DEPTH is a power of two: the write index wraps to 0 when the stack fills.
    localparam int IDX_W = $clog2(DEPTH);

    logic [PC_W-1:0]  mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             full_q;

    assign rd_idx = wr_idx - 1'b1;
    assign top    = mem[rd_idx];
    assign full   = full_q;
    assign empty  = (wr_idx == '0) && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx <= '0;
            full_q <= 1'b0;
        end else if (push) begin
            mem[wr_idx] <= din;
            wr_idx      <= wr_idx + 1'b1;
            full_q      <= (wr_idx == IDX_W'(DEPTH - 1));
        end else if (pop) begin
            wr_idx <= rd_idx;
            full_q <= 1'b0;
        end
    end

    p_push_room_r8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    p_pop_data_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    p_single_op_r7: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

    p_push_leaves_data_r6: assert property (@(posedge clk) disable iff (rst)
        push |=> !empty);

endmodule

// File: rtl/seq_pc_ctrl.sv
module seq_pc_ctrl
    import seq_pc_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFF_W = 7,
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic              br_i,
    input  logic [2:0]        mode_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              ovf_o,
    output logic              unf_o
);
    br_mode_e        mode;
    br_act_t         act;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] stk_top;
    logic            stk_full;
    logic            stk_empty;
    logic            do_push;
    logic            do_pop;
    logic            ovf_q;
    logic            unf_q;

    assign mode = br_mode_e'(mode_i);

    seq_br_decide #(.PC_W(PC_W), .OFF_W(OFF_W)) i_decide (
        .mode   (mode),
        .flag_n (flag_n_i),
        .flag_z (flag_z_i),
        .pc     (pc_q),
        .offset (offset_i),
        .act    (act),
        .target (target)
    );

    assign do_push = br_i && act.call && !stk_full;
    assign do_pop  = br_i && act.ret  && !stk_empty;

    seq_ret_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) i_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (do_push),
        .pop   (do_pop),
        .din   (pc_q),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    always_comb begin
        pc_d = pc_q;
        if (br_i) begin
            if (act.jump)    pc_d = target;
            else if (do_pop) pc_d = stk_top;
        end else if (adv_i) begin
            pc_d = pc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            pc_q <= pc_d;
            if (br_i && act.call && stk_full)  ovf_q <= 1'b1;
            if (br_i && act.ret  && stk_empty) unf_q <= 1'b1;
        end
    end

    assign pc_o  = pc_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && !ovf_q && !unf_q));

    p_adv_step_r2: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !br_i) |=> pc_q == PC_W'($past(pc_q) + 1'b1));

    p_none_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (br_i && mode_i == 3'b101) |=> $stable(pc_q));

    p_underflow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (br_i && mode_i == 3'b111 && stk_empty) |=> ($stable(pc_q) && unf_q));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(ovf_q) && !$past(rst)) |-> ovf_q);

    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(unf_q) && !$past(rst)) |-> unf_q);

endmodule

// File: tb/test_seq_pc_ctrl.sv
module test_seq_pc_ctrl;
    localparam int PERIOD = 10;
    localparam int PC_W   = 12;
    localparam int OFF_W  = 7;
    localparam int DEPTH  = 16;
    localparam int MASK   = (1 << PC_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             adv_i = 1'b0;
    logic             br_i = 1'b0;
    logic [2:0]       mode_i = '0;
    logic [OFF_W-1:0] offset_i = '0;
    logic             flag_n_i = 1'b0;
    logic             flag_z_i = 1'b0;
    logic [PC_W-1:0]  pc_o;
    logic             ovf_o;
    logic             unf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural reference
    int m_pc  = 0;
    bit m_ovf = 1'b0;
    bit m_unf = 1'b0;
    int m_stk[$];

    always #(PERIOD/2) clk = ~clk;

    seq_pc_ctrl #(.PC_W(PC_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) i_seq_pc_ctrl (
        .clk(clk), .rst(rst), .adv_i(adv_i), .br_i(br_i), .mode_i(mode_i),
        .offset_i(offset_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i),
        .pc_o(pc_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    function automatic bit test_ok(int md, bit n, bit z);
        case (md)
            0: return 1'b1;
            1: return !z;
            2: return z;
            3: return !n;
            4: return n;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model(bit r, bit a, bit b, int md, int off, bit n, bit z);
        if (r) begin
            m_pc = 0; m_ovf = 0; m_unf = 0; m_stk.delete();
        end else if (b) begin
            if (md <= 4) begin
                if (test_ok(md, n, z)) m_pc = (m_pc + off) & MASK;
            end else if (md == 6) begin
                if (m_stk.size() == DEPTH) m_ovf = 1;
                else m_stk.push_back(m_pc);
                m_pc = (m_pc + off) & MASK;
            end else if (md == 7) begin
                if (m_stk.size() == 0) m_unf = 1;
                else m_pc = m_stk.pop_back();
            end
        end else if (a) begin
            m_pc = (m_pc + 1) & MASK;
        end
    endtask

    task automatic cmp(string tag);
        checks++;
        if (int'(pc_o) != m_pc || ovf_o != m_ovf || unf_o != m_unf) begin
            errors++;
            $display("FAIL %s: pc=%03h ovf=%0b unf=%0b expected pc=%03h ovf=%0b unf=%0b",
                     tag, pc_o, ovf_o, unf_o, m_pc[PC_W-1:0], m_ovf, m_unf);
        end
    endtask

    // One clock: drive at the falling edge, model at the rising edge, compare at the next fall.
    task automatic step(bit r, bit a, bit b, int md, int off, bit n, bit z, string tag);
        rst = r; adv_i = a; br_i = b; mode_i = 3'(md);
        offset_i = OFF_W'(off); flag_n_i = n; flag_z_i = z;
        @(posedge clk);
        model(r, a, b, md, off, n, z);
        @(negedge clk);
        cmp(tag);
    endtask

    task automatic adv(string tag);
        step(0, 1, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic br(int md, int off, bit n, bit z, string tag);
        step(0, 0, 1, md, off, n, z, tag);
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 1, 1, 0, 5, 0, 0, "R1");
        // R2 advancing
        for (int i = 0; i < 5; i++) adv("R2");
        // R3 unconditional, forward and backward
        br(0, 20, 0, 0, "R3");
        br(0, -7, 1, 1, "R3");
        // R11 wrap below zero, then R2 wrap at the top
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        br(0, -1, 0, 0, "R11");
        adv("R2");
        br(0, -64, 0, 0, "R11");
        br(0, 63, 0, 0, "R11");
        // R4 every conditional mode with each flag combination
        for (int md = 1; md <= 4; md++)
            for (int f = 0; f < 4; f++) begin
                br(md, 9, f[1], f[0], "R4");
                adv("R4");
            end
        // R5 reserved mode, with advance also high
        step(0, 1, 1, 5, 30, 1, 1, "R5");
        br(5, -30, 0, 0, "R5");
        // R10 branch beats advance, both taken and not taken
        step(0, 1, 1, 0, 12, 0, 0, "R10");
        step(0, 1, 1, 2, 12, 0, 0, "R10");
        // R6/R7 nested calls and returns
        br(6, 40, 0, 0, "R6");
        adv("R6");
        br(6, -15, 0, 0, "R6");
        br(6, 3, 0, 0, "R6");
        br(7, 0, 0, 0, "R7");
        br(7, 0, 0, 0, "R7");
        adv("R7");
        br(7, 0, 0, 0, "R7");
        // R9 return on empty stack
        br(7, 0, 0, 0, "R9");
        adv("R9");
        br(7, 0, 0, 0, "R9");
        // R1 reset clears flags; return afterwards underflows
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        br(7, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        // R8 fill the stack, overflow, then unwind all of it
        for (int i = 0; i < DEPTH; i++) begin
            br(6, 5 + i, 0, 0, "R8");
            adv("R8");
        end
        br(6, -20, 0, 0, "R8");
        br(6, 11, 0, 0, "R8");
        for (int i = 0; i < DEPTH; i++) br(7, 0, 0, 0, "R8");
        br(7, 0, 0, 0, "R9");
        adv("R8");
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule